// File: doc/BRIEF.md
# Decode-Stage Hazard Gate for Equality Branches

This block sits beside the decode stage of a five-stage in-order pipeline in which equality branches are resolved in decode. Each cycle it looks at the two source register numbers of the instruction being decoded, at whether that instruction is a conditional branch, and at the destination register and flags of the instructions now in execute and memory. From these it decides whether the decoded instruction has to wait, and whether a taken branch has to discard the instruction fetched behind it.

When a wait is needed, the gate holds the program counter and the fetch/decode register, so the same instruction is fetched and decoded again, and it asks the decode stage to pass an all-zero control word into execute. That zero word makes the slot a no-op bubble. ALU consumers wait one bubble behind a load and then use forwarding. A branch compared in decode cannot use the execute-stage ALU result, so it waits one bubble behind an ALU producer and two behind a load. When a branch in decode finds its operands equal and no wait is pending, the gate clears the instruction just fetched, so a taken branch costs one slot.

The gate is purely combinational. The operand values it compares come from the decode-stage read ports after any decode-stage forwarding.

Top module: `hazard_gate`

## Requirements
- R1: When `ex_memread` is 1 and a nonzero `ex_rd` equals `id_rs` or `id_rt`, the gate stalls: `pc_we`=0, `ifid_we`=0, `ctrl_zero`=1. This holds whether or not `id_branch` is set.
- R2: `pc_we` and `ifid_we` are always equal. Both are 0 during a stall and 1 otherwise.
- R3: `ctrl_zero` is 1 exactly in the cycles where `pc_we` is 0, so every hold comes with exactly one bubble.
- R4: When `id_branch` is 1, `ex_regwrite` is 1 and a nonzero `ex_rd` equals `id_rs` or `id_rt`, the gate stalls.
- R5: When `id_branch` is 1, `mem_memread` is 1 and a nonzero `mem_rd` equals `id_rs` or `id_rt`, the gate stalls. Together with R1, a branch right behind a load of its operand waits two cycles.
- R6: A non-branch instruction does not stall on an ALU producer in execute. No instruction stalls on a producer in memory unless that producer is a load and the consumer is a branch.
- R7: A destination register number of 0 never causes a stall.
- R8: When `id_branch` is 1, `id_opa` equals `id_opb` in every bit, and no stall is requested, `if_flush` is 1.
- R9: When a stall and a taken branch fall in the same cycle, the stall wins. The gate then sets `if_flush`=0 and `ctrl_zero`=1.
- R10: `if_flush` is 0 whenever `id_branch` is 0 or the two operands differ in at least one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_AW | First source register number in decode |
| id_rt | input | REG_AW | Second source register number in decode |
| id_branch | input | 1 | Decoded instruction is an equality branch |
| id_opa | input | DATA_W | First branch operand value read in decode |
| id_opb | input | DATA_W | Second branch operand value read in decode |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Force the control word into execute to zero |
| if_flush | output | 1 | Clear the instruction in the fetch/decode register |

## Verification
A stall and a taken-branch flush can be requested in the same cycle. This happens when a branch in decode has equal operands while one of those operands is still being produced in execute, or is being loaded in memory. The bench sets up these collisions directly: equal operand values are driven together with a matching `ex_rd` or `mem_rd`. It expects the hold and the bubble with no flush. Random vectors draw register numbers from a small range, so the collision also turns up often without being aimed at. Each random vector is judged against a reference function written from the requirements.

// File: rtl/hazard_gate.sv
module hazard_gate #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_branch,
  input  logic [DATA_W-1:0] id_opa,
  input  logic [DATA_W-1:0] id_opb,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_memread,
  input  logic              ex_regwrite,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_memread,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              ctrl_zero,
  output logic              if_flush
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_hit, mem_hit;
  logic load_use, br_on_alu, br_on_load;
  logic stall, same;

  assign ex_hit  = (ex_rd  != ZERO_REG) && (ex_rd  == id_rs || ex_rd  == id_rt);
  assign mem_hit = (mem_rd != ZERO_REG) && (mem_rd == id_rs || mem_rd == id_rt);

  assign load_use   = ex_memread && ex_hit;
  assign br_on_alu  = id_branch && ex_regwrite && ex_hit;
  assign br_on_load = id_branch && mem_memread && mem_hit;
  assign stall      = load_use || br_on_alu || br_on_load;

  assign same = ~|(id_opa ^ id_opb);

  assign pc_we     = ~stall;
  assign ifid_we   = ~stall;
  assign ctrl_zero = stall;
  assign if_flush  = id_branch && same && !stall;

  always_comb begin
    a_r2_hold_pair: assert (pc_we == ifid_we);
    a_r3_bubble_with_hold: assert (ctrl_zero == !pc_we);
    if (ex_rd == ZERO_REG && mem_rd == ZERO_REG)
      a_r7_zero_dest_quiet: assert (pc_we && !ctrl_zero);
    if (ctrl_zero)
      a_r9_stall_beats_flush: assert (!if_flush);
    if (if_flush)
      a_r10_flush_needs_equal_branch: assert (id_branch && id_opa == id_opb);
    if (ex_memread && ex_rd != ZERO_REG && ex_rd == id_rs)
      a_r1_load_use_holds: assert (!pc_we);
  end

endmodule

// File: tb/hazard_gate_tb_top.sv
module hazard_gate_tb_top;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rd, mem_rd;
  logic          id_branch, ex_memread, ex_regwrite, mem_memread;
  logic [DW-1:0] id_opa, id_opb;
  logic          pc_we, ifid_we, ctrl_zero, if_flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazard_gate #(.REG_AW(AW), .DATA_W(DW)) dut_i (
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .id_opa(id_opa), .id_opb(id_opb),
    .ex_rd(ex_rd), .ex_memread(ex_memread), .ex_regwrite(ex_regwrite),
    .mem_rd(mem_rd), .mem_memread(mem_memread),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero), .if_flush(if_flush)
  );

  function automatic bit exp_stall();
    bit exh, memh;
    exh  = ex_rd  != 0 && (ex_rd  == id_rs || ex_rd  == id_rt);
    memh = mem_rd != 0 && (mem_rd == id_rs || mem_rd == id_rt);
    return (ex_memread && exh) || (id_branch && ex_regwrite && exh) ||
           (id_branch && mem_memread && memh);
  endfunction

  function automatic logic [3:0] expected();
    bit s;
    s = exp_stall();
    return {!s, !s, s, id_branch && (id_opa == id_opb) && !s};
  endfunction

  task automatic check(string tag);
    logic [3:0] got, exp;
    @(negedge clk);
    got = {pc_we, ifid_we, ctrl_zero, if_flush};
    exp = expected();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got pc/ifid/zero/flush=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] rs, rt, input logic br,
                       input logic [DW-1:0] a, b,
                       input logic [AW-1:0] erd, input logic emr, ewr,
                       input logic [AW-1:0] mrd, input logic mmr);
    @(posedge clk);
    #1;
    id_rs = rs; id_rt = rt; id_branch = br; id_opa = a; id_opb = b;
    ex_rd = erd; ex_memread = emr; ex_regwrite = ewr;
    mem_rd = mrd; mem_memread = mmr;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 R3 idle state");
    drive(3, 7, 0, 1, 2, 3, 1, 1, 0, 0);
    check("R1 load-use on rs");
    drive(3, 7, 0, 1, 2, 7, 1, 1, 0, 0);
    check("R1 load-use on rt");
    drive(3, 7, 0, 1, 2, 3, 0, 1, 0, 0);
    check("R6 alu producer no stall for alu user");
    drive(3, 7, 0, 1, 2, 0, 0, 0, 3, 1);
    check("R6 load in mem no stall for alu user");
    drive(3, 7, 1, 5, 9, 7, 0, 1, 0, 0);
    check("R4 branch on alu result");
    drive(3, 7, 1, 5, 5, 3, 1, 1, 0, 0);
    check("R9 R1 branch on load first cycle, equal operands");
    drive(3, 7, 1, 5, 5, 0, 0, 0, 3, 1);
    check("R5 R9 branch on load second cycle");
    drive(3, 7, 1, 5, 5, 0, 0, 0, 0, 0);
    check("R8 taken branch flushes");
    drive(3, 7, 1, 5, 4, 0, 0, 0, 0, 0);
    check("R10 not-equal branch no flush");
    drive(3, 7, 0, 5, 5, 0, 0, 0, 0, 0);
    check("R10 equal operands but no branch");
    drive(0, 0, 1, 8, 8, 0, 1, 1, 0, 1);
    check("R7 zero destination never stalls");
    drive(3, 7, 1, 8, 8, 0, 0, 1, 3, 0);
    check("R6 branch with alu producer in mem");
    drive(3, 7, 1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);
    check("R10 msb difference");
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] a;
      a = $urandom;
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            a, ($urandom_range(0, 1) != 0) ? a : a ^ (32'd1 << $urandom_range(0, 31)),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1));
      check("R1 R4 R5 R7 R8 R9 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule